// File: doc/BRIEF.md
# Wide Operand RAM Staging Port

This block sits between a 32-bit register bus and the operand store of a modular exponentiation engine. The store holds rows of 192 bits, and each row is assembled from six 32-bit words. Software writes the six words into staging registers and then writes a row selector. That selector write is the event that stores the staged row. To fetch a row, software writes a read selector. One clock later the row lands in six read-data registers, and a ready flag in the status word rises when they are valid.

The store is divided into fixed regions of 22 rows, one region per operand: modulus, exponent, digest, result and so on. A selector names a region and a row inside it, and the block turns that into the linear row region × 22 + row. Operands are kept least-significant word first. Row 0, word 0 of a region holds bits 31:0 of its operand. A 4096-bit operand uses 128 of the region's 132 words, and the exponent uses only its lowest word. Software writes zero to every word an operand does not use.

The store has a single port. While the engine signals busy, the engine owns that port, and every bus access is refused with an error pulse.

Top module: `opram_stage`

## Requirements
- R1: After reset, every readable bus offset returns zero and eng_rdata_o is zero.
- R2: Bus offsets 0 to 5 are the staging words 0 to 5. Each can be written and read back.
- R3: A bus write to offset 6 stores the staged words as one row. Staging word k goes to row bits 32k+31:32k. Selector field bits 10:8 give the region and bits 4:0 give the row within it. The row stored to is region × 22 + row.
- R4: A bus write of a selector to offset 7 clears status bit 0 (ready) in the next cycle. One clock later ready is 1, and offsets 8 to 13 return words 0 to 5 of the selected row.
- R5: A selector whose row is 22 or more, or whose region is NUM_RGN or more, is ignored by both offset 6 and offset 7. Such a selector sets sticky status bit 1 (map error). No row is written, and the ready flag and the read data keep their values.
- R6: A bus write to offset 14 with bit 1 set clears the map error. A write to offset 14 with bit 1 clear leaves the map error set.
- R7: While eng_busy_i is 1, a bus request raises bus_err_o in the same cycle and returns zero read data. A write made while busy changes nothing.
- R8: While eng_busy_i is 1, eng_we_i writes eng_wdata_i to row eng_row_i. With eng_we_i at 0, eng_rdata_o shows row eng_row_i one clock later.
- R9: The same row number in different regions maps to different rows. Region 1 row 0 is row 22, and region 5 row 21 is row 131.
- R10: A read load that falls due while eng_busy_i is 1 waits, with ready held at 0. It completes one clock after busy falls and returns the row contents at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word offset of the register |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, combinational |
| bus_err_o | output | 1 | Access refused because the engine is busy |
| eng_busy_i | input | 1 | Engine owns the store |
| eng_we_i | input | 1 | Engine row write |
| eng_row_i | input | AW | Engine linear row |
| eng_wdata_i | input | 192 | Engine write row |
| eng_rdata_o | output | 192 | Engine read row, registered |

## Verification
The assertions assume that bus inputs are known after reset and that eng_we_i matters only while eng_busy_i is high. They also assume that eng_row_i stays below 132 whenever the engine reads. The bench meets these conditions by design:
- It drives every input at the falling edge.
- It raises eng_we_i only together with busy.
- It keeps engine rows inside the map.

The bench also reaches a load that is postponed by busy by raising busy in the cycle right after a selector write.

// File: rtl/opram_pkg.sv
package opram_pkg;
  localparam int unsigned DW           = 32;
  localparam int unsigned WORDS        = 6;
  localparam int unsigned ROWS_PER_RGN = 22;
  localparam int unsigned NUM_RGN      = 6;
  // bus word offsets; software depends on these
  localparam int unsigned OFF_COMMIT   = 6;
  localparam int unsigned OFF_RSEL     = 7;
  localparam int unsigned OFF_RD0      = 8;
  localparam int unsigned OFF_STAT     = 14;
  localparam int unsigned ROW_FLD_W    = 5;
  localparam int unsigned RGN_FLD_W    = 3;
endpackage

// File: rtl/opram_map.sv
module opram_map #(
  parameter int unsigned N_RGN  = 6,
  parameter int unsigned N_ROWS = 22,
  parameter int unsigned AW     = 8,
  parameter int unsigned ROW_FW = 5,
  parameter int unsigned RGN_FW = 3
) (
  input  logic [RGN_FW-1:0] rgn_i,
  input  logic [ROW_FW-1:0] row_i,
  output logic [AW-1:0]     phys_o,
  output logic              ok_o
);
  logic [15:0] lin;

  always_comb begin
    ok_o   = (32'(row_i) < N_ROWS) && (32'(rgn_i) < N_RGN);
    lin    = 16'(rgn_i) * 16'(N_ROWS) + 16'(row_i);
    phys_o = lin[AW-1:0];
  end

  // R3: a selector that is inside the map gives a row inside the store
  always_comb begin
    if (ok_o) a_r3_in_map: assert (32'(lin) < N_RGN * N_ROWS);
  end
endmodule

// File: rtl/opram_store.sv
module opram_store #(
  parameter int unsigned DEPTH = 132,
  parameter int unsigned AW    = 8,
  parameter int unsigned W     = 192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];
  logic         in_rng;

  assign in_rng  = 32'(addr_i) < DEPTH;
  assign rdata_o = in_rng ? mem[addr_i] : '0;

  always_ff @(posedge clk_i) begin
    if (we_i && in_rng) mem[addr_i] <= wdata_i;
  end

  // R3/R8: a write is visible at the same row one clock later
  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_rng) |=> (mem[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/opram_regs.sv
module opram_regs #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_WORDS = 6,
  parameter int unsigned AW      = 8,
  parameter int unsigned ROW_W   = DATA_W * N_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  input  logic              busy_i,
  input  logic [AW-1:0]     phys_i,
  input  logic              map_ok_i,
  output logic              port_we_o,
  output logic [AW-1:0]     port_addr_o,
  output logic [ROW_W-1:0]  port_wdata_o,
  input  logic [ROW_W-1:0]  port_rdata_i
);
  localparam logic [3:0] A_COMMIT = 4'(opram_pkg::OFF_COMMIT);
  localparam logic [3:0] A_RSEL   = 4'(opram_pkg::OFF_RSEL);
  localparam logic [3:0] A_STAT   = 4'(opram_pkg::OFF_STAT);
  localparam int unsigned RD0     = opram_pkg::OFF_RD0;

  logic [DATA_W-1:0] stage_q [N_WORDS];
  logic [ROW_W-1:0]  rd_q;
  logic [AW-1:0]     raddr_q;
  logic pend_q, ready_q, err_q;
  logic acc, wr, commit, rsel, bad, load, clr;

  assign acc    = bus_req_i && !busy_i;
  assign wr     = acc && bus_we_i;
  assign commit = wr && (bus_addr_i == A_COMMIT) && map_ok_i;
  assign rsel   = wr && (bus_addr_i == A_RSEL) && map_ok_i;
  assign bad    = wr && ((bus_addr_i == A_COMMIT) || (bus_addr_i == A_RSEL)) && !map_ok_i;
  assign clr    = wr && (bus_addr_i == A_STAT) && bus_wdata_i[1];
  // load yields the single port to the engine and to a commit
  assign load   = pend_q && !busy_i && !commit && !rsel;

  assign bus_err_o   = bus_req_i && busy_i;
  assign port_we_o   = commit;
  assign port_addr_o = commit ? phys_i : raddr_q;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_pack
    assign port_wdata_o[k*DATA_W +: DATA_W] = stage_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_WORDS; k++) stage_q[k] <= '0;
      rd_q    <= '0;
      raddr_q <= '0;
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      for (int k = 0; k < N_WORDS; k++)
        if (wr && bus_addr_i == 4'(k)) stage_q[k] <= bus_wdata_i;
      if (bad)      err_q <= 1'b1;
      else if (clr) err_q <= 1'b0;
      if (rsel) begin
        raddr_q <= phys_i;
        pend_q  <= 1'b1;
        ready_q <= 1'b0;
      end else if (load) begin
        rd_q    <= port_rdata_i;
        pend_q  <= 1'b0;
        ready_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (acc && !bus_we_i) begin
      for (int k = 0; k < N_WORDS; k++) begin
        if (bus_addr_i == 4'(k))       bus_rdata_o = stage_q[k];
        if (bus_addr_i == 4'(RD0 + k)) bus_rdata_o = rd_q[k*DATA_W +: DATA_W];
      end
      if (bus_addr_i == A_STAT) bus_rdata_o = DATA_W'({err_q, ready_q});
    end
  end

  logic [ROW_W-1:0] stage_flat;
  assign stage_flat = port_wdata_o;

  a_r4_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsel |=> !ready_q);
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr) |=> err_q);
  a_r7_stage_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(stage_flat));
  a_r10_no_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && pend_q) |=> ($stable(rd_q) && !ready_q));
endmodule

// File: rtl/opram_stage.sv
module opram_stage #(
  parameter int unsigned DATA_W  = opram_pkg::DW,
  parameter int unsigned N_WORDS = opram_pkg::WORDS,
  parameter int unsigned N_ROWS  = opram_pkg::ROWS_PER_RGN,
  parameter int unsigned N_RGN   = opram_pkg::NUM_RGN,
  parameter int unsigned ROW_W   = DATA_W * N_WORDS,
  parameter int unsigned DEPTH   = N_ROWS * N_RGN,
  parameter int unsigned AW      = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  input  logic              eng_busy_i,
  input  logic              eng_we_i,
  input  logic [AW-1:0]     eng_row_i,
  input  logic [ROW_W-1:0]  eng_wdata_i,
  output logic [ROW_W-1:0]  eng_rdata_o
);
  localparam int unsigned ROW_FW = opram_pkg::ROW_FLD_W;
  localparam int unsigned RGN_FW = opram_pkg::RGN_FLD_W;

  logic [AW-1:0]    phys, r_addr, p_addr;
  logic             map_ok, r_we, p_we;
  logic [ROW_W-1:0] r_wdata, p_wdata, p_rdata;

  opram_map #(.N_RGN(N_RGN), .N_ROWS(N_ROWS), .AW(AW), .ROW_FW(ROW_FW), .RGN_FW(RGN_FW)) i_map (
    .rgn_i  (bus_wdata_i[8 +: RGN_FW]),
    .row_i  (bus_wdata_i[0 +: ROW_FW]),
    .phys_o (phys),
    .ok_o   (map_ok)
  );

  opram_regs #(.DATA_W(DATA_W), .N_WORDS(N_WORDS), .AW(AW), .ROW_W(ROW_W)) i_regs (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .bus_err_o,
    .busy_i       (eng_busy_i),
    .phys_i       (phys),
    .map_ok_i     (map_ok),
    .port_we_o    (r_we),
    .port_addr_o  (r_addr),
    .port_wdata_o (r_wdata),
    .port_rdata_i (p_rdata)
  );

  // single port: engine owns it while busy
  assign p_we    = eng_busy_i ? eng_we_i    : r_we;
  assign p_addr  = eng_busy_i ? eng_row_i   : r_addr;
  assign p_wdata = eng_busy_i ? eng_wdata_i : r_wdata;

  opram_store #(.DEPTH(DEPTH), .AW(AW), .W(ROW_W)) i_store (
    .clk_i, .rst_ni,
    .we_i    (p_we),
    .addr_i  (p_addr),
    .wdata_i (p_wdata),
    .rdata_o (p_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      eng_rdata_o <= '0;
    else if (eng_busy_i && !eng_we_i) eng_rdata_o <= p_rdata;
  end

  // R7: the bus is refused exactly while the engine is busy
  a_r7_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && eng_busy_i) |-> (bus_err_o && bus_rdata_o == '0));
endmodule

// File: tb/test_opram_stage.sv
module test_opram_stage;
  localparam int AW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_err;
  logic eng_busy = 0, eng_we = 0;
  logic [AW-1:0] eng_row = '0;
  logic [191:0] eng_wdata = '0, eng_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  opram_stage i_opram_stage (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_err_o(bus_err), .eng_busy_i(eng_busy), .eng_we_i(eng_we),
    .eng_row_i(eng_row), .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata)
  );

  task automatic chk(string tag, logic [191:0] act, logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int rg, int rw, int k, int salt);
    return 32'hC000_0000 ^ 32'(salt << 24) ^ 32'(rg << 16) ^ 32'(rw << 8) ^ 32'(k);
  endfunction

  function automatic logic [191:0] row_of(int rg, int rw, int salt);
    logic [191:0] r;
    for (int k = 0; k < 6; k++) r[k*32 +: 32] = pat(rg, rw, k, salt);
    return r;
  endfunction

  function automatic logic [31:0] sel(int rg, int rw);
    return 32'((rg << 8) | rw);
  endfunction

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  // combinational read inside the low phase
  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_req = 0;
  endtask

  task automatic rd_row(output logic [191:0] r);
    logic [31:0] d;
    for (int k = 0; k < 6; k++) begin
      bus_rd(4'(8 + k), d);
      r[k*32 +: 32] = d;
    end
  endtask

  task automatic store_row(int rg, int rw, int salt);
    for (int k = 0; k < 6; k++) bus_wr(4'(k), pat(rg, rw, k, salt));
    bus_wr(4'd6, sel(rg, rw));
  endtask

  task automatic fetch_row(int rg, int rw, output logic [191:0] r);
    bus_wr(4'd7, sel(rg, rw));
    @(posedge clk); @(negedge clk);
    rd_row(r);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 15; a++) begin
      bus_rd(4'(a), d);
      chk($sformatf("R1 offset %0d", a), 192'(d), '0);
    end
    chk("R1 eng_rdata", eng_rdata, '0);
  endtask

  task automatic t_stage();
    logic [31:0] d;
    for (int k = 0; k < 6; k++) bus_wr(4'(k), pat(7, 7, k, 1));
    for (int k = 0; k < 6; k++) begin
      bus_rd(4'(k), d);
      chk($sformatf("R2 stage word %0d", k), 192'(d), 192'(pat(7, 7, k, 1)));
    end
  endtask

  task automatic t_commit_read();
    logic [31:0] d;
    logic [191:0] r;
    store_row(0, 3, 2);
    bus_wr(4'd7, sel(0, 3));
    bus_rd(4'd14, d);
    chk("R4 ready low after selector", 192'(d[0]), 0);
    @(posedge clk); @(negedge clk);
    bus_rd(4'd14, d);
    chk("R4 ready high one clock later", 192'(d[0]), 1);
    rd_row(r);
    chk("R3 R4 row words in order", r, row_of(0, 3, 2));
  endtask

  task automatic t_regions();
    logic [31:0] d;
    logic [191:0] r;
    store_row(1, 0, 3);
    store_row(5, 21, 4);
    store_row(0, 0, 5);
    bus_wr(4'd7, sel(1, 0));
    bus_rd(4'd14, d);
    chk("R4 ready drops again", 192'(d[0]), 0);
    @(posedge clk); @(negedge clk);
    rd_row(r);
    chk("R9 region1 row0", r, row_of(1, 0, 3));
    fetch_row(5, 21, r);
    chk("R9 region5 row21", r, row_of(5, 21, 4));
    fetch_row(0, 0, r);
    chk("R9 region0 row0 separate", r, row_of(0, 0, 5));
    @(negedge clk);
    eng_busy = 1; eng_row = 8'd22;
    @(posedge clk); @(negedge clk);
    chk("R9 R8 linear row 22", eng_rdata, row_of(1, 0, 3));
    eng_row = 8'd131;
    @(posedge clk); @(negedge clk);
    chk("R9 R8 linear row 131", eng_rdata, row_of(5, 21, 4));
    eng_busy = 0;
  endtask

  task automatic t_bad();
    logic [31:0] d;
    logic [191:0] r;
    for (int k = 0; k < 6; k++) bus_wr(4'(k), 32'hDEAD_0000 | 32'(k));
    bus_wr(4'd6, sel(0, 22));
    bus_rd(4'd14, d);
    chk("R5 err set by row 22", 192'(d[1]), 1);
    bus_wr(4'd6, sel(6, 0));
    fetch_row(1, 0, r);
    chk("R5 bad commit wrote nothing", r, row_of(1, 0, 3));
    bus_wr(4'd7, sel(2, 30));
    @(posedge clk); @(negedge clk);
    bus_rd(4'd14, d);
    chk("R5 bad read selector keeps ready", 192'(d[0]), 1);
    rd_row(r);
    chk("R5 bad read selector keeps data", r, row_of(1, 0, 3));
    bus_wr(4'd14, 32'h1);
    bus_rd(4'd14, d);
    chk("R6 err kept without bit1", 192'(d[1]), 1);
    bus_wr(4'd14, 32'h2);
    bus_rd(4'd14, d);
    chk("R6 err cleared", 192'(d[1]), 0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    bus_wr(4'd0, 32'h1234_5678);
    @(negedge clk);
    eng_busy = 1;
    bus_req = 1; bus_we = 0; bus_addr = 4'd0;
    #0.5;
    chk("R7 err pulse", 192'(bus_err), 1);
    chk("R7 read data zero", 192'(bus_rdata), '0);
    bus_we = 1; bus_wdata = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    bus_req = 0; bus_we = 0; eng_busy = 0;
    #0.5 chk("R7 err gone when idle", 192'(bus_err), 0);
    bus_rd(4'd0, d);
    chk("R7 write while busy ignored", 192'(d), 192'(32'h1234_5678));
  endtask

  task automatic t_engine();
    logic [191:0] r;
    @(negedge clk);
    eng_busy = 1; eng_we = 1; eng_row = 8'd40; eng_wdata = row_of(9, 9, 6);
    @(posedge clk); @(negedge clk);
    eng_we = 0;
    @(posedge clk); @(negedge clk);
    chk("R8 engine read back", eng_rdata, row_of(9, 9, 6));
    eng_busy = 0;
    fetch_row(1, 18, r);
    chk("R8 R3 engine row 40 is region1 row18", r, row_of(9, 9, 6));
  endtask

  task automatic t_pending();
    logic [31:0] d;
    logic [191:0] r;
    bus_wr(4'd7, sel(0, 0));
    eng_busy = 1; eng_we = 1; eng_row = 8'd0; eng_wdata = row_of(8, 8, 7);
    @(posedge clk); @(negedge clk);
    eng_we = 0;
    @(posedge clk); @(negedge clk);
    eng_busy = 0;
    bus_rd(4'd14, d);
    chk("R10 ready held low through busy", 192'(d[0]), 0);
    @(posedge clk); @(negedge clk);
    bus_rd(4'd14, d);
    chk("R10 ready after busy falls", 192'(d[0]), 1);
    rd_row(r);
    chk("R10 load sees engine data", r, row_of(8, 8, 7));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_commit_read();
    t_regions();
    t_bad();
    t_busy();
    t_engine();
    t_pending();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule